// File: doc/BRIEF.md
# Row/Column Multiplexed Parallel Bus Front End

This block is the parallel front end that production programming equipment uses to reach a byte-wide memory. A 20-bit byte address does not fit the 11 address pins, so the equipment sends it in two halves. The falling edge of a row/column select strobe captures the lower half. The rising edge of the same strobe captures the upper half.

Once the address is latched, the bus control lines decide what happens:
- Holding output enable low while write enable stays high reads a byte from the attached memory model. That byte is driven onto the data bus.
- Pulsing write enable low and then high hands the data byte and the latched address to a command port as a single-cycle write strobe.
- Holding the bus reset low turns the block quiet. On release, it returns to reading.

All bus control strobes come from an asynchronous equipment domain. Each one passes through a two-flop synchroniser, and edges are detected after synchronisation. The address and data inputs are delayed by the same number of stages, so each capture sees the value present at the strobe edge.

Top module: `rcbus_front`

## Requirements
- R1: On a falling edge of `rcSel`, all 11 bits of `addrIn` are stored as address bits 10..0. Address bits 19..11 are left unchanged.
- R2: On a rising edge of `rcSel`, `addrIn[8:0]` is stored as address bits 19..11. Address bits 10..0 are left unchanged.
- R3: With `oeN` low, `weN` high and `busRstN` high, `memRdStb` is high and `memAddr` is the latched address. `dataOe` is high and `dataOut` carries the byte returned on `memRdData`. These values appear within three clock edges of the last input change.
- R4: While `oeN` is high, `dataOe` is low, so the data bus is in high impedance.
- R5: A rising edge of `weN` while `oeN` is high and `busRstN` is high produces `cmdWrStb` for exactly one clock. In that cycle, `cmdAddr` is the latched address and `cmdData` is the `dataIn` value present at the rising edge.
- R6: While `busRstN` is low, `dataOe`, `memRdStb` and `cmdWrStb` stay low. `rcSel` edges during that time do not change the latched address.
- R7: After `busRstN` returns high, the block reads again with no further command. If `oeN` is already low, the data bus is driven with the byte at the previously latched address.
- R8: While `weN` and `oeN` are both low, no read takes place and `dataOe` stays low. A `weN` rising edge that occurs while `oeN` is low produces no `cmdWrStb`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| sysRstN | input | 1 | Active-low system reset of the block's flops |
| addrIn | input | 11 | Multiplexed address pins |
| rcSel | input | 1 | Row/column select strobe (falling edge: low half, rising edge: high half) |
| oeN | input | 1 | Active-low output enable |
| weN | input | 1 | Active-low write enable |
| busRstN | input | 1 | Active-low bus reset from the equipment |
| dataIn | input | 8 | Data bus as driven by the equipment |
| dataOut | output | 8 | Data bus value driven by the block |
| dataOe | output | 1 | High when the block drives the data bus |
| memRdStb | output | 1 | Read strobe to the byte memory model |
| memAddr | output | 20 | Latched byte address presented to the memory model |
| memRdData | input | 8 | Byte returned by the memory model for `memAddr` |
| cmdWrStb | output | 1 | One-cycle write strobe to the command port |
| cmdAddr | output | 20 | Address captured with the write |
| cmdData | output | 8 | Data byte captured with the write |

## Verification
Address halves are sent as a patterned row with an all-ones column, then as their swapped counterparts. This shows that each strobe edge fills only its own half and that the column takes the low nine pins. Writes are tried with different data and addresses in a row, and a scoreboard matches every command strobe against its expected item. That separates a strobe taken on the wrong edge, a stale data capture, and a repeated pulse. Both-low enable cycles and activity during bus reset act as negative patterns. Any strobe during them is unexpected. A read after reset release must return the byte at the address latched before the reset.

// File: rtl/rcbus_pkg.sv
package rcbus_pkg;
  // strobes from control to datapath, one clock wide except readEn (level)
  typedef struct packed {
    logic latchRow;
    logic latchCol;
    logic capWrite;
    logic readEn;
  } busCtl_t;
endpackage

// File: rtl/rcbus_ctrl.sv
module rcbus_ctrl
  import rcbus_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    sysRstN,
  input  logic    rcSel,
  input  logic    weN,
  input  logic    oeN,
  input  logic    busRstN,
  output busCtl_t ctl
);
  localparam int NSIG = 4;
  // bit order: [3] bus reset, [2] oeN, [1] weN, [0] rcSel; idle levels
  localparam logic [NSIG-1:0] IDLE = 4'b0111;

  logic [NSIG-1:0] rawIn;
  logic [NSIG-1:0] chain [SYNC_STAGES+1];
  logic [NSIG-1:0] cur;
  logic [NSIG-1:0] prv;
  logic            live;

  assign rawIn = {busRstN, oeN, weN, rcSel};

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      for (int i = 0; i <= SYNC_STAGES; i++) chain[i] <= IDLE;
    end else begin
      chain[0] <= rawIn;
      for (int i = 1; i <= SYNC_STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign cur  = chain[SYNC_STAGES-1];
  assign prv  = chain[SYNC_STAGES];
  assign live = cur[3];

  always_comb begin
    ctl.latchRow = live && prv[0] && !cur[0];
    ctl.latchCol = live && !prv[0] && cur[0];
    ctl.capWrite = live && !prv[1] && cur[1] && cur[2];
    ctl.readEn   = live && cur[1] && !cur[2];
  end
endmodule

// File: rtl/rcbus_dpath.sv
module rcbus_dpath
  import rcbus_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ROW_W       = 11,
  parameter int COL_W       = 9,
  parameter int DATA_W      = 8
) (
  input  logic                   clk,
  input  logic                   sysRstN,
  input  busCtl_t                ctl,
  input  logic [ROW_W-1:0]       addrIn,
  input  logic [DATA_W-1:0]      dataIn,
  input  logic [DATA_W-1:0]      memRdData,
  output logic [ROW_W+COL_W-1:0] latchedAddr,
  output logic [DATA_W-1:0]      dataOut,
  output logic                   dataOe,
  output logic                   cmdWrStb,
  output logic [ROW_W+COL_W-1:0] cmdAddr,
  output logic [DATA_W-1:0]      cmdData
);
  localparam int ADDR_W = ROW_W + COL_W;

  // delay address and data like the control strobes so captures line up
  logic [ROW_W-1:0]  addrPipe [SYNC_STAGES];
  logic [DATA_W-1:0] dataPipe [SYNC_STAGES];
  logic [ROW_W-1:0]  rowReg;
  logic [COL_W-1:0]  colReg;

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) begin
        addrPipe[i] <= '0;
        dataPipe[i] <= '0;
      end
    end else begin
      addrPipe[0] <= addrIn;
      dataPipe[0] <= dataIn;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        addrPipe[i] <= addrPipe[i-1];
        dataPipe[i] <= dataPipe[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      rowReg <= '0;
      colReg <= '0;
    end else begin
      if (ctl.latchRow) rowReg <= addrPipe[SYNC_STAGES-1];
      if (ctl.latchCol) colReg <= addrPipe[SYNC_STAGES-1][COL_W-1:0];
    end
  end

  assign latchedAddr = {colReg, rowReg};

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      cmdWrStb <= 1'b0;
      cmdAddr  <= '0;
      cmdData  <= '0;
      dataOe   <= 1'b0;
      dataOut  <= '0;
    end else begin
      cmdWrStb <= ctl.capWrite;
      if (ctl.capWrite) begin
        cmdAddr <= latchedAddr;
        cmdData <= dataPipe[SYNC_STAGES-1];
      end
      dataOe <= ctl.readEn;
      if (ctl.readEn) dataOut <= memRdData;
    end
  end

  a_r1_col_kept: assert property (@(posedge clk) disable iff (!sysRstN)
    ctl.latchRow |=> $stable(colReg));
  a_r2_row_kept: assert property (@(posedge clk) disable iff (!sysRstN)
    ctl.latchCol |=> $stable(rowReg));
  a_r5_one_cycle: assert property (@(posedge clk) disable iff (!sysRstN)
    cmdWrStb |=> !cmdWrStb);
  a_r8_no_drive_on_write: assert property (@(posedge clk) disable iff (!sysRstN)
    cmdWrStb |-> !dataOe);
endmodule

// File: rtl/rcbus_front.sv
module rcbus_front
  import rcbus_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ROW_W       = 11,
  parameter int COL_W       = 9,
  parameter int DATA_W      = 8
) (
  input  logic                   clk,
  input  logic                   sysRstN,
  input  logic [ROW_W-1:0]       addrIn,
  input  logic                   rcSel,
  input  logic                   oeN,
  input  logic                   weN,
  input  logic                   busRstN,
  input  logic [DATA_W-1:0]      dataIn,
  output logic [DATA_W-1:0]      dataOut,
  output logic                   dataOe,
  output logic                   memRdStb,
  output logic [ROW_W+COL_W-1:0] memAddr,
  input  logic [DATA_W-1:0]      memRdData,
  output logic                   cmdWrStb,
  output logic [ROW_W+COL_W-1:0] cmdAddr,
  output logic [DATA_W-1:0]      cmdData
);
  busCtl_t ctl;

  rcbus_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .sysRstN(sysRstN), .rcSel(rcSel), .weN(weN),
    .oeN(oeN), .busRstN(busRstN), .ctl(ctl)
  );

  rcbus_dpath #(
    .SYNC_STAGES(SYNC_STAGES), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)
  ) uDpath (
    .clk(clk), .sysRstN(sysRstN), .ctl(ctl), .addrIn(addrIn), .dataIn(dataIn),
    .memRdData(memRdData), .latchedAddr(memAddr), .dataOut(dataOut),
    .dataOe(dataOe), .cmdWrStb(cmdWrStb), .cmdAddr(cmdAddr), .cmdData(cmdData)
  );

  assign memRdStb = ctl.readEn;

  a_r6_reset_quiet: assert property (@(posedge clk) disable iff (!sysRstN)
    ($past(!busRstN, 2) && $past(!busRstN, 3)) |-> (!memRdStb && !cmdWrStb && !dataOe));
endmodule

// File: tb/tb_rcbus_front.sv
`timescale 1ns/1ps
module tb_rcbus_front;
  logic        clk = 1'b0;
  logic        sysRstN = 1'b0;
  logic [10:0] addrIn = '0;
  logic        rcSel = 1'b1;
  logic        oeN = 1'b1;
  logic        weN = 1'b1;
  logic        busRstN = 1'b0;
  logic [7:0]  dataIn = '0;
  logic [7:0]  dataOut;
  logic        dataOe;
  logic        memRdStb;
  logic [19:0] memAddr;
  logic [7:0]  memRdData;
  logic        cmdWrStb;
  logic [19:0] cmdAddr;
  logic [7:0]  cmdData;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  logic [27:0] expQ [$];   // {addr, data}

  always #4 clk = ~clk;

  rcbus_front dut (
    .clk(clk), .sysRstN(sysRstN), .addrIn(addrIn), .rcSel(rcSel), .oeN(oeN),
    .weN(weN), .busRstN(busRstN), .dataIn(dataIn), .dataOut(dataOut),
    .dataOe(dataOe), .memRdStb(memRdStb), .memAddr(memAddr),
    .memRdData(memRdData), .cmdWrStb(cmdWrStb), .cmdAddr(cmdAddr), .cmdData(cmdData)
  );

  function automatic logic [7:0] memByte(logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h5A;
  endfunction
  assign memRdData = memByte(memAddr);

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor for command writes (R5, R6, R8)
  always @(negedge clk) begin
    if (sysRstN && cmdWrStb) begin
      tests++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R5/R6/R8 unexpected write actual=%h_%h expected=none", cmdAddr, cmdData);
      end else begin
        logic [27:0] e;
        e = expQ.pop_front();
        if ({cmdAddr, cmdData} !== e) begin
          fails++;
          $display("FAIL R5 write actual=%h expected=%h", {cmdAddr, cmdData}, e);
        end
      end
    end
  end

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendAddr(logic [10:0] row, logic [8:0] col);
    addrIn = row; rcSel = 1'b0; waitN(4);
    addrIn = {2'b00, col}; rcSel = 1'b1; waitN(4);
  endtask

  task automatic busWrite(logic [7:0] d, logic [19:0] a, bit expect_it);
    if (expect_it) expQ.push_back({a, d});
    dataIn = d; weN = 1'b0; waitN(4);
    weN = 1'b1; waitN(4);
  endtask

  task automatic readCheck(logic [19:0] a, string req);
    oeN = 1'b0; waitN(4);
    check(dataOe === 1'b1 && memRdStb === 1'b1, req, {dataOe, memRdStb}, 2'b11);
    check(memAddr === a, req, memAddr, a);
    check(dataOut === memByte(a), req, dataOut, memByte(a));
    oeN = 1'b1; waitN(4);
    check(dataOe === 1'b0, "R4 oe high", dataOe, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    waitN(3);
    sysRstN = 1'b1;
    waitN(2);
    // R6: bus reset held, outputs quiet
    check(dataOe === 0 && memRdStb === 0 && cmdWrStb === 0, "R6 reset state",
          {dataOe, memRdStb, cmdWrStb}, 0);
    busRstN = 1'b1; waitN(4);
    check(dataOe === 0, "R4 idle", dataOe, 0);

    // R1/R2: row patterned, column all ones
    sendAddr(11'h5A3, 9'h1FF);
    readCheck({9'h1FF, 11'h5A3}, "R1 R2 R3 read 1");
    sendAddr(11'h2A5, 9'h0C3);
    readCheck({9'h0C3, 11'h2A5}, "R1 R2 R3 read 2");

    // R1: only the row half changes (rc falls, then stays low across a read)
    addrIn = 11'h7FF; rcSel = 1'b0; waitN(4);
    readCheck({9'h0C3, 11'h7FF}, "R1 row only");
    // R2: only the column half changes
    addrIn = 11'h611; rcSel = 1'b1; waitN(4);
    readCheck({9'h011, 11'h7FF}, "R2 col only (upper pins ignored)");

    // R5: writes
    busWrite(8'hA5, {9'h011, 11'h7FF}, 1);
    sendAddr(11'h001, 9'h100);
    busWrite(8'h3C, {9'h100, 11'h001}, 1);
    busWrite(8'hFF, {9'h100, 11'h001}, 1);

    // R8: both enables low, no read, no write
    oeN = 1'b0; dataIn = 8'h77; weN = 1'b0; waitN(5);
    check(dataOe === 0 && memRdStb === 0, "R8 both low no read", {dataOe, memRdStb}, 0);
    weN = 1'b1; waitN(1);
    oeN = 1'b1; waitN(5);
    check(dataOe === 0, "R8 R4 after both low", dataOe, 0);

    // R6: activity during bus reset is ignored
    busRstN = 1'b0; waitN(4);
    oeN = 1'b0; waitN(4);
    check(dataOe === 0 && memRdStb === 0, "R6 read blocked", {dataOe, memRdStb}, 0);
    oeN = 1'b1;
    sendAddr(11'h0F0, 9'h0AA);
    busWrite(8'h11, 20'h0, 0);
    oeN = 1'b0; waitN(2);
    // R7: release with oeN low, reads old address
    busRstN = 1'b1; waitN(4);
    check(dataOe === 1'b1, "R7 read resumes", dataOe, 1);
    check(memAddr === {9'h100, 11'h001}, "R6 address kept", memAddr, {9'h100, 11'h001});
    check(dataOut === memByte({9'h100, 11'h001}), "R7 data", dataOut,
          memByte({9'h100, 11'h001}));
    oeN = 1'b1; waitN(4);

    waitN(4);
    check(expQ.size() == 0, "R5 all writes seen", expQ.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule